// File: doc/BRIEF.md
# External Memory Bus Controller with Programmable Wait States

This block runs external memory cycles for a small processor core. The external bus has separate address and data lines, so no external address latch is needed. Each cycle drives exactly one of three active-low strobes: instruction fetch from program memory, data read, or data write. The controller runs on a clock whose period is one half-period of the processor clock. It therefore places every bus edge at half-period resolution.

The internal side is a level request with a cycle kind, an address and write data. The requester holds the request until it sees a one-tick acknowledge, and read data is valid in that acknowledge tick. The strobe width is 2+2n ticks. For fetches, n comes from a 2-bit program wait setting. For data cycles, n comes from a 3-bit data wait setting. Both settings are captured when the request is accepted. Fetch cycles get two ticks of address setup before the strobe and data cycles get one. Every cycle holds the address for one tick after the strobe rises, then spends at least one idle tick before the next cycle starts.

Top module: `emc_bus_ctrl`

## Requirements
- R1: While reset is high and after its release, all three strobes are high, the acknowledge is low and the data output enable is low.
- R2: The request kind selects the strobe. Kind 2'b00 drives only `prog_rd_n`. Kinds 2'b01 and 2'b11 drive only `data_rd_n`. Kind 2'b10 drives only `data_wr_n`. At most one strobe is ever low.
- R3: The selected strobe stays low for exactly 2+2n consecutive ticks. For kind 2'b00, n is `prog_wait` (0 to 3); for the other kinds, n is `data_wait` (0 to 7).
- R4: The request address appears on `bus_addr` in the tick after acceptance. The strobe falls after 2 ticks of setup for fetches and after 1 tick for data cycles. The address stays stable until the end of the acknowledge tick, which follows the strobe's rise.
- R5: For read kinds, `rd_data` in the acknowledge tick equals the value on `bus_din` at the clock edge where the strobe rises.
- R6: `ack` is high for exactly one tick: the first tick after the strobe returns high.
- R7: `bus_dout_en` is high only for kind 2'b10, from the first setup tick through the acknowledge tick. While it is high, `bus_dout` carries the request write data. It is low in every tick of the other kinds.
- R8: Changing `prog_wait` or `data_wait` after a request is accepted has no effect on that cycle's strobe width.
- R9: If a request is held high across an acknowledge, exactly one idle tick follows, with all strobes high and the output enable low. The next cycle is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one half-period of the processor clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request, held until acknowledged |
| req_kind | input | 2 | Cycle kind: 00 fetch, 01/11 data read, 10 data write |
| req_addr | input | 20 | Request address |
| req_wdata | input | 8 | Write data |
| prog_wait | input | 2 | Wait count for fetch cycles |
| data_wait | input | 3 | Wait count for data cycles |
| ack | output | 1 | One-tick completion pulse |
| rd_data | output | 8 | Captured read data, valid with ack |
| bus_addr | output | 20 | External address bus |
| bus_dout | output | 8 | External data bus, outbound value |
| bus_dout_en | output | 1 | External data bus output enable |
| bus_din | input | 8 | External data bus, inbound value |
| prog_rd_n | output | 1 | Program memory read strobe, active low |
| data_rd_n | output | 1 | Data memory read strobe, active low |
| data_wr_n | output | 1 | Data memory write strobe, active low |

## Verification
Two pairs of events can land in the same tick. The first is read-data capture, which happens on the same edge as the strobe's rise, in the tick right before the acknowledge. The bench's memory model drives valid data only while a read strobe is low and drives a filler value otherwise. A capture taken one tick late therefore returns the filler instead of the address-derived byte. The second pair is releasing the output enable after a write and starting a following cycle. It is provoked by holding the request across the acknowledge with a new kind, and judged by checking the idle tick and the later strobe edges tick by tick.

// File: rtl/emc_pkg.sv
package emc_pkg;
    localparam int ADDR_W   = 20;
    localparam int DATA_W   = 8;
    localparam int PWAIT_W  = 2;
    localparam int DWAIT_W  = 3;
    localparam int MAX_WAIT = (1 << DWAIT_W) - 1;
    localparam int MAX_STB  = 2 + 2 * MAX_WAIT;
    localparam int CNT_W    = $clog2(MAX_STB + 1);

    typedef enum logic [1:0] {
        CYC_FETCH  = 2'b00,
        CYC_DREAD  = 2'b01,
        CYC_DWRITE = 2'b10,
        CYC_DREAD2 = 2'b11
    } cyc_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        cyc_e              kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    function automatic logic [CNT_W-1:0] strobe_len(input logic [DWAIT_W-1:0] n);
        return CNT_W'(2) + (CNT_W'(n) << 1);
    endfunction

    function automatic logic is_read(input cyc_e k);
        return (k == CYC_DREAD) || (k == CYC_DREAD2);
    endfunction
endpackage

// File: rtl/emc_seq.sv
module emc_seq
    import emc_pkg::*;
#(
    parameter int SETUP_FETCH = 2,
    parameter int SETUP_DATA  = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  cyc_e               kind_in,
    input  logic [PWAIT_W-1:0] pwait,
    input  logic [DWAIT_W-1:0] dwait,
    output phase_e             phase,
    output logic               last_tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] stb_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            stb_len <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (req) begin
                    phase <= PH_SETUP;
                    if (kind_in == CYC_FETCH) begin
                        cnt     <= CNT_W'(SETUP_FETCH - 1);
                        stb_len <= strobe_len(DWAIT_W'(pwait));
                    end else begin
                        cnt     <= CNT_W'(SETUP_DATA - 1);
                        stb_len <= strobe_len(dwait);
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_STROBE;
                        cnt   <= stb_len - CNT_W'(1);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_STROBE: begin
                    if (cnt == '0) phase <= PH_HOLD;
                    else           cnt   <= cnt - CNT_W'(1);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign last_tick = (phase == PH_STROBE) && (cnt == '0);

    // R3: the countdown inside the strobe never exceeds the latched length
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STROBE) |-> (cnt < stb_len));
    // R3: strobe length is even and at least two ticks
    p_len_even_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STROBE) |-> (stb_len[0] == 1'b0 && stb_len >= CNT_W'(2)));
    // R9: the hold tick is always followed by an idle tick
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD) |=> (phase == PH_IDLE));
endmodule

// File: rtl/emc_capture.sv
module emc_capture
    import emc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  xfer_t             xfer_in,
    input  logic              cap,
    input  logic [DATA_W-1:0] din,
    output xfer_t             xfer_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_q  <= '{kind: CYC_FETCH, addr: '0, wdata: '0};
            rdata_q <= '0;
        end else begin
            if (load) xfer_q  <= xfer_in;
            if (cap)  rdata_q <= din;
        end
    end

    // R4: the latched address changes only on acceptance
    p_addr_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(xfer_q.addr));
    // R5: read data only moves at a capture edge
    p_rdata_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(rdata_q));
endmodule

// File: rtl/emc_bus_ctrl.sv
module emc_bus_ctrl
    import emc_pkg::*;
#(
    parameter int SETUP_FETCH = 2,
    parameter int SETUP_DATA  = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic [1:0]         req_kind,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [PWAIT_W-1:0] prog_wait,
    input  logic [DWAIT_W-1:0] data_wait,
    output logic               ack,
    output logic [DATA_W-1:0]  rd_data,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_dout,
    output logic               bus_dout_en,
    input  logic [DATA_W-1:0]  bus_din,
    output logic               prog_rd_n,
    output logic               data_rd_n,
    output logic               data_wr_n
);
    phase_e phase;
    logic   last_tick;
    logic   accept;
    xfer_t  xfer_in;
    xfer_t  xfer_q;
    logic   active;
    logic   strobing;

    assign xfer_in = '{kind: cyc_e'(req_kind), addr: req_addr, wdata: req_wdata};
    assign accept  = req && (phase == PH_IDLE);

    emc_seq #(
        .SETUP_FETCH(SETUP_FETCH),
        .SETUP_DATA (SETUP_DATA)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .kind_in  (cyc_e'(req_kind)),
        .pwait    (prog_wait),
        .dwait    (data_wait),
        .phase    (phase),
        .last_tick(last_tick)
    );

    emc_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .xfer_in(xfer_in),
        .cap    (last_tick),
        .din    (bus_din),
        .xfer_q (xfer_q),
        .rdata_q(rd_data)
    );

    assign active      = (phase == PH_STROBE);
    assign prog_rd_n   = !(active && xfer_q.kind == CYC_FETCH);
    assign data_rd_n   = !(active && is_read(xfer_q.kind));
    assign data_wr_n   = !(active && xfer_q.kind == CYC_DWRITE);
    assign bus_dout_en = (phase != PH_IDLE) && (xfer_q.kind == CYC_DWRITE);
    assign bus_dout    = xfer_q.wdata;
    assign bus_addr    = xfer_q.addr;
    assign ack         = (phase == PH_HOLD);
    assign strobing    = !(prog_rd_n && data_rd_n && data_wr_n);

    // R2: never more than one strobe low
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        $countones({~prog_rd_n, ~data_rd_n, ~data_wr_n}) <= 1);
    // R6: acknowledge follows a strobe and sees all strobes high
    p_ack_after_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        ack |-> ($past(strobing) && !strobing));
    // R6: acknowledge lasts a single tick
    p_ack_single_r6: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    // R7: output enable never overlaps a read strobe
    p_oe_no_read_r7: assert property (@(posedge clk) disable iff (rst)
        bus_dout_en |-> (prog_rd_n && data_rd_n));
    // R4: address stable while a strobe is low and through the hold tick
    p_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(strobing) && (strobing || ack)) |-> $stable(bus_addr));
endmodule

// File: tb/emc_bus_ctrl_test.sv
module emc_bus_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [1:0]  prog_wait = '0;
    logic [2:0]  data_wait = '0;
    logic        ack;
    logic [7:0]  rd_data;
    logic [19:0] bus_addr;
    logic [7:0]  bus_dout;
    logic        bus_dout_en;
    logic [7:0]  bus_din;
    logic        prog_rd_n;
    logic        data_rd_n;
    logic        data_wr_n;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [19:0] a);
        return a[7:0] ^ a[19:12] ^ 8'h3C;
    endfunction

    // memory model: data valid only while a read strobe is low
    assign bus_din = (!prog_rd_n || !data_rd_n) ? mem_f(bus_addr) : 8'hEE;

    emc_bus_ctrl uut (
        .clk(clk), .rst(rst), .req(req), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .prog_wait(prog_wait), .data_wait(data_wait),
        .ack(ack), .rd_data(rd_data), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
        .prog_rd_n(prog_rd_n), .data_rd_n(data_rd_n), .data_wr_n(data_wr_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [4:0] quiet_vec();
        return {ack, bus_dout_en, prog_rd_n, data_rd_n, data_wr_n};
    endfunction

    task automatic run_cycle(input logic [1:0] ty, input int pw, input int dw,
                             input logic [19:0] a, input logic [7:0] wd,
                             input int extra, input bit chg_wait, input bit keep);
        int s, n, w, t, last;
        bit lo, rd_ty;
        logic [2:0] exp_s;
        req = 1'b1; req_kind = ty; req_addr = a; req_wdata = wd;
        prog_wait = pw[1:0]; data_wait = dw[2:0];
        s = (ty == 2'b00) ? 2 : 1;
        n = (ty == 2'b00) ? pw : dw;
        w = 2 + 2 * n;
        last = s + w + 1;
        rd_ty = (ty == 2'b01) || (ty == 2'b11);
        for (int k = 1; k <= extra + last; k++) begin
            @(negedge clk);
            t = k - extra;
            if (t <= 0) begin
                chk(quiet_vec() == 5'b00111, "R9", quiet_vec(), 5'b00111, "idle gap tick");
            end else begin
                if (chg_wait && t == 1) begin
                    prog_wait = ~prog_wait;
                    data_wait = ~data_wait;
                end
                lo = (t >= s + 1) && (t <= s + w);
                exp_s = {!(lo && ty == 2'b00), !(lo && rd_ty), !(lo && ty == 2'b10)};
                chk({prog_rd_n, data_rd_n, data_wr_n} == exp_s, chg_wait ? "R8" : "R3",
                    {prog_rd_n, data_rd_n, data_wr_n}, exp_s, "strobe pattern");
                if (t == s + 1)
                    chk({prog_rd_n, data_rd_n, data_wr_n} == exp_s, "R2",
                        {prog_rd_n, data_rd_n, data_wr_n}, exp_s, "strobe select");
                chk(bus_addr == a, "R4", bus_addr, a, "address window");
                chk(ack == (t == last), "R6", ack, (t == last), "ack timing");
                chk(bus_dout_en == (ty == 2'b10), "R7", bus_dout_en, (ty == 2'b10), "output enable");
                if (bus_dout_en)
                    chk(bus_dout == wd, "R7", bus_dout, wd, "write data");
                if (t == last) begin
                    if (rd_ty || ty == 2'b00)
                        chk(rd_data == mem_f(a), "R5", rd_data, mem_f(a), "read capture");
                    if (!keep) req = 1'b0;
                end
            end
        end
        if (!keep) begin
            @(negedge clk);
            chk(quiet_vec() == 5'b00111, "R7", quiet_vec(), 5'b00111, "release after cycle");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(quiet_vec() == 5'b00111, "R1", quiet_vec(), 5'b00111, "in reset");
        rst = 1'b0;
        @(negedge clk);
        chk(quiet_vec() == 5'b00111, "R1", quiet_vec(), 5'b00111, "after reset");
        chk(rd_data == 8'h00, "R1", rd_data, 8'h00, "read data reset");

        for (int p = 0; p < 4; p++) begin
            run_cycle(2'b00, p, 7 - p, 20'h12345 + 20'(p * 20'h0F0F1), 8'h00, 0, 0, 0);
            run_cycle(2'b00, p, 0, 20'hFFFFF - 20'(p), 8'h00, 0, 0, 0);
        end
        for (int d = 0; d < 8; d++) begin
            run_cycle(2'b01, 3 - (d % 4), d, 20'hA5000 + 20'(d * 20'h01357), 8'h00, 0, 0, 0);
            run_cycle(2'b10, d % 4, d, 20'h00000 + 20'(d * 20'h11111), 8'(8'h81 + d * 8'h13), 0, 0, 0);
        end
        run_cycle(2'b11, 0, 0, 20'h3C3C3, 8'h00, 0, 0, 0);
        run_cycle(2'b11, 0, 5, 20'h80001, 8'h00, 0, 0, 0);
        // R8: wait settings changed after acceptance
        run_cycle(2'b00, 1, 0, 20'h0ABCD, 8'h00, 0, 1, 0);
        run_cycle(2'b10, 0, 3, 20'h54321, 8'h5A, 0, 1, 0);
        // R9: back-to-back requests
        run_cycle(2'b10, 0, 2, 20'h11223, 8'hC3, 0, 0, 1);
        run_cycle(2'b01, 0, 0, 20'h11224, 8'h00, 1, 0, 1);
        run_cycle(2'b00, 3, 0, 20'h7E7E7, 8'h00, 1, 0, 1);
        run_cycle(2'b10, 0, 7, 20'h00001, 8'h3E, 1, 0, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule